// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number and an offset, into a physical address. It keeps a small on-chip table of segments, each with a starting physical address (base) and a length (limit), plus a separate count of how many table entries are currently legal. Software-side logic fills the table through a write port and sets the legal-entry count through a second write strobe. Changing that count and rewriting the entries is all a context change needs. No per-entry invalidation exists.

A request carries a segment number and an offset under a valid/ready handshake. One cycle after a request is accepted, a registered response appears. It holds either the translated address or an addressing-error trap, and the trap has a two-bit cause. Two independent legality tests guard the add. The segment number is compared against the legal-entry count, and the offset against the selected entry's limit. A carry out of the base-plus-offset sum is also reported as a trap.

Top module: `seg_xlate`

## Requirements
- R1: After reset no response is pending (`rsp_valid` low, `req_ready` high), the legal-entry count is 0, and every entry is cleared, so any lookup traps with cause 2'b01.
- R2: A request whose segment number is greater than or equal to the legal-entry count returns `rsp_trap`=1, `rsp_cause`=2'b01 and `rsp_paddr`=0.
- R3: A request with a legal segment number whose offset is greater than or equal to that entry's limit returns `rsp_trap`=1, `rsp_cause`=2'b10 and `rsp_paddr`=0. For example, with base 4600 and limit 400, offset 400 traps.
- R4: A request that passes both tests returns `rsp_trap`=0, `rsp_cause`=2'b00 and `rsp_paddr` equal to base plus offset. For example, with base 4600 and limit 400, offset 399 gives 4999.
- R5: When base plus offset does not fit in `ADDR_W` bits, the result is a trap with cause 2'b10, even if the offset is below the limit.
- R6: When the segment number is illegal and the offset is also out of range, the cause is 2'b01. The segment test has priority, and the cause never has both bits set.
- R7: A request accepted at a clock edge shows up on the response port right after that same edge, which is a latency of one cycle.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response fields hold their values.
- R9: A table-entry or count write issued in the same cycle as an accepted request does not affect that request. It applies from the next cycle on.
- R10: A count write larger than `SEG_COUNT` stores `SEG_COUNT`, so segment numbers at or above `SEG_COUNT` always trap with cause 2'b01.
- R11: Writing only the legal-entry count changes which segments are legal. The stored entries are kept, so a segment made legal again translates as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W (3) | Entry written |
| tbl_base | input | ADDR_W (16) | Base written into the entry |
| tbl_limit | input | ADDR_W (16) | Limit written into the entry |
| len_we | input | 1 | Legal-entry count write strobe |
| len_val | input | LEN_W (4) | New legal-entry count (saturated) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_seg | input | SNUM_W (4) | Segment number of the request |
| req_off | input | ADDR_W (16) | Offset of the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | ADDR_W (16) | Physical address, 0 on trap |
| rsp_trap | output | 1 | Addressing-error trap |
| rsp_cause | output | 2 | 00 none, 01 bad segment, 10 offset/overflow |

## Verification
Two functions can land in the same cycle: a table or count write, and the acceptance of a lookup that reads the entry being rewritten. The bench drives both strobes on one edge. It expects the lookup to return the result computed from the table as it stood before the write, and it expects the lookup that follows to see the new contents. A second overlap, an illegal segment number together with an out-of-range offset, is provoked through a segment whose cleared entry has limit 0. That case is judged on the cause code alone.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_SEG   = 2'b01,
      CAUSE_RANGE = 2'b10
   } trap_cause_e;
endpackage

// File: rtl/seg_table_store.sv
module seg_table_store #(
   parameter int SEG_COUNT = 8,
   parameter int ADDR_W    = 16,
   parameter int IDX_W     = 3,
   parameter int LEN_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] rd_limit,
   output logic [LEN_W-1:0]  len_q
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(SEG_COUNT);

   logic [ADDR_W-1:0] base_arr  [SEG_COUNT];
   logic [ADDR_W-1:0] limit_arr [SEG_COUNT];

   for (genvar e = 0; e < SEG_COUNT; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_arr[e]  <= '0;
            limit_arr[e] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            base_arr[e]  <= wr_base;
            limit_arr[e] <= wr_limit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         len_q <= '0;
      else if (len_we)
         len_q <= (len_wdata > LEN_MAX) ? LEN_MAX : len_wdata;
   end

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      if (int'(rd_idx) < SEG_COUNT) begin
         rd_base  = base_arr[rd_idx];
         rd_limit = limit_arr[rd_idx];
      end
   end

   // R10: stored count never exceeds the table depth
   a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LEN_MAX);
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SNUM_W     = 4,
   parameter int LEN_W      = 4,
   parameter bit CARRY_TRAP = 1'b1
) (
   input  logic [SNUM_W-1:0] seg_num,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  tbl_len,
   input  logic [ADDR_W-1:0] ent_base,
   input  logic [ADDR_W-1:0] ent_limit,
   output logic              trap,
   output trap_cause_e       cause,
   output logic [ADDR_W-1:0] paddr
);
   localparam int CMP_W = (SNUM_W > LEN_W) ? SNUM_W : LEN_W;

   logic [CMP_W-1:0]  seg_ext, len_ext;
   logic [ADDR_W:0]   sum;
   logic              seg_bad, off_bad, ovf_bad;

   assign seg_ext = CMP_W'(seg_num);
   assign len_ext = CMP_W'(tbl_len);
   assign seg_bad = (seg_ext >= len_ext);
   assign off_bad = (offset >= ent_limit);
   assign sum     = {1'b0, ent_base} + {1'b0, offset};

   if (CARRY_TRAP) begin : g_carry_trap
      assign ovf_bad = sum[ADDR_W];
   end else begin : g_carry_wrap
      assign ovf_bad = 1'b0;
   end

   always_comb begin
      trap  = 1'b0;
      cause = CAUSE_NONE;
      paddr = sum[ADDR_W-1:0];
      if (seg_bad) begin
         trap  = 1'b1;
         cause = CAUSE_SEG;
         paddr = '0;
      end else if (off_bad || ovf_bad) begin
         trap  = 1'b1;
         cause = CAUSE_RANGE;
         paddr = '0;
      end
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_COUNT  = 8,
   parameter int ADDR_W     = 16,
   parameter int SNUM_W     = 4,
   parameter bit CARRY_TRAP = 1'b1,
   localparam int IDX_W     = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
   localparam int LEN_W     = $clog2(SEG_COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] tbl_limit,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SNUM_W-1:0] req_seg,
   input  logic [ADDR_W-1:0] req_off,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_trap,
   output logic [1:0]        rsp_cause
);
   if (SEG_COUNT < 1)       begin : g_bad_count  $error("SEG_COUNT must be at least 1"); end
   if (ADDR_W < 2)          begin : g_bad_addr   $error("ADDR_W must be at least 2"); end
   if (SNUM_W < IDX_W)      begin : g_bad_snum   $error("SNUM_W narrower than table index"); end

   logic [ADDR_W-1:0] ent_base, ent_limit;
   logic [LEN_W-1:0]  len_q;
   logic              chk_trap;
   trap_cause_e       chk_cause;
   logic [ADDR_W-1:0] chk_paddr;
   logic              accept;

   seg_table_store #(
      .SEG_COUNT (SEG_COUNT),
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .LEN_W     (LEN_W)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_we),
      .wr_idx    (tbl_idx),
      .wr_base   (tbl_base),
      .wr_limit  (tbl_limit),
      .len_we    (len_we),
      .len_wdata (len_val),
      .rd_idx    (req_seg[IDX_W-1:0]),
      .rd_base   (ent_base),
      .rd_limit  (ent_limit),
      .len_q     (len_q)
   );

   seg_check #(
      .ADDR_W     (ADDR_W),
      .SNUM_W     (SNUM_W),
      .LEN_W      (LEN_W),
      .CARRY_TRAP (CARRY_TRAP)
   ) check_i (
      .seg_num   (req_seg),
      .offset    (req_off),
      .tbl_len   (len_q),
      .ent_base  (ent_base),
      .ent_limit (ent_limit),
      .trap      (chk_trap),
      .cause     (chk_cause),
      .paddr     (chk_paddr)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CAUSE_NONE;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (accept) begin
            rsp_paddr <= chk_paddr;
            rsp_trap  <= chk_trap;
            rsp_cause <= chk_cause;
         end
      end
   end

   // R7: an accepted request is answered after the next edge
   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   // R8: a stalled response holds and blocks new requests
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                     && $stable(rsp_trap) && $stable(rsp_cause)));
   a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
   // R2/R3: a trap carries a cause and a zero address; success carries neither
   a_r2_cause_matches_trap: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_trap == (rsp_cause != 2'b00)) && (!rsp_trap || rsp_paddr == '0)));
   // R6: never both cause bits
   a_r6_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_cause));
endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
   localparam int SEG_COUNT = 8;
   localparam int ADDR_W    = 16;
   localparam int SNUM_W    = 4;
   localparam int IDX_W     = 3;
   localparam int LEN_W     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tbl_we = 1'b0;
   logic [IDX_W-1:0]  tbl_idx = '0;
   logic [ADDR_W-1:0] tbl_base = '0, tbl_limit = '0;
   logic              len_we = 1'b0;
   logic [LEN_W-1:0]  len_val = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [SNUM_W-1:0] req_seg = '0;
   logic [ADDR_W-1:0] req_off = '0;
   logic              rsp_valid;
   logic              rsp_ready = 1'b1;
   logic [ADDR_W-1:0] rsp_paddr;
   logic              rsp_trap;
   logic [1:0]        rsp_cause;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   seg_xlate #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W), .SNUM_W(SNUM_W)) dut_i (
      .clk, .rst_n, .tbl_we, .tbl_idx, .tbl_base, .tbl_limit, .len_we, .len_val,
      .req_valid, .req_ready, .req_seg, .req_off,
      .rsp_valid, .rsp_ready, .rsp_paddr, .rsp_trap, .rsp_cause);

   // bench model of the table
   logic [ADDR_W-1:0] m_base  [SEG_COUNT];
   logic [ADDR_W-1:0] m_limit [SEG_COUNT];
   int                m_len;

   // scoreboard: {trap, cause, paddr}
   logic [ADDR_W+2:0] exp_q [$];
   string             tag_q [$];

   function automatic logic [ADDR_W+2:0] expect_of(int seg, logic [ADDR_W-1:0] off);
      logic [ADDR_W:0] s;
      if (seg >= m_len) return {1'b1, 2'b01, {ADDR_W{1'b0}}};
      s = {1'b0, m_base[seg]} + {1'b0, off};
      if (off >= m_limit[seg] || s[ADDR_W]) return {1'b1, 2'b10, {ADDR_W{1'b0}}};
      return {1'b0, 2'b00, s[ADDR_W-1:0]};
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected response", 1, 0);
         end else begin
            logic [ADDR_W+2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({rsp_trap, rsp_cause, rsp_paddr} == e, t, "response {trap,cause,paddr}",
                  int'({rsp_trap, rsp_cause, rsp_paddr}), int'(e));
         end
      end
   end

   task automatic tbl_write(int idx, int b, int l);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_base = ADDR_W'(b); tbl_limit = ADDR_W'(l);
      @(negedge clk);
      tbl_we = 1'b0;
      m_base[idx] = ADDR_W'(b); m_limit[idx] = ADDR_W'(l);
   endtask

   task automatic len_write(int v);
      @(negedge clk);
      len_we = 1'b1; len_val = LEN_W'(v);
      @(negedge clk);
      len_we = 1'b0;
      m_len = (v > SEG_COUNT) ? SEG_COUNT : v;
   endtask

   // optional same-cycle table write (wr_kind: 0 none, 1 entry, 2 count)
   task automatic send_w(int seg, int off, string tag, int wr_kind, int idx, int b, int l);
      @(negedge clk);
      exp_q.push_back(expect_of(seg, ADDR_W'(off)));
      tag_q.push_back(tag);
      req_valid = 1'b1; req_seg = SNUM_W'(seg); req_off = ADDR_W'(off);
      if (wr_kind == 1) begin
         tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_base = ADDR_W'(b); tbl_limit = ADDR_W'(l);
      end else if (wr_kind == 2) begin
         len_we = 1'b1; len_val = LEN_W'(b);
      end
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; tbl_we = 1'b0; len_we = 1'b0;
      check(rsp_valid == 1'b1, "R7", "rsp_valid one cycle after accept", int'(rsp_valid), 1);
      if (wr_kind == 1) begin m_base[idx] = ADDR_W'(b); m_limit[idx] = ADDR_W'(l); end
      if (wr_kind == 2) m_len = (b > SEG_COUNT) ? SEG_COUNT : b;
   endtask

   task automatic send(int seg, int off, string tag);
      send_w(seg, off, tag, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [ADDR_W-1:0] held;
      for (int i = 0; i < SEG_COUNT; i++) begin m_base[i] = '0; m_limit[i] = '0; end
      m_len = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      send(0, 0, "R1");

      // load a table
      tbl_write(0, 1400, 1000);
      tbl_write(1, 6300, 400);
      tbl_write(2, 4600, 400);
      tbl_write(3, 16'hFF00, 16'hFFFF);
      tbl_write(4, 3200, 1100);
      tbl_write(7, 100, 50);
      len_write(5);

      send(2, 399, "R4");
      send(2, 400, "R3");
      send(2, 0, "R4");
      send(0, 999, "R4");
      send(4, 1100, "R3");
      send(5, 0, "R2");
      send(9, 16'hFFFF, "R6");
      send(6, 0, "R6");
      send(3, 16'h00FF, "R5");
      send(3, 16'h0100, "R5");

      // R10 saturation
      len_write(15);
      send(7, 49, "R10");
      send(8, 0, "R10");
      send(15, 0, "R10");

      // R11 count-only context change
      len_write(2);
      send(2, 399, "R11");
      len_write(5);
      send(2, 399, "R11");

      // R9 same-cycle writes
      send_w(2, 10, "R9", 1, 2, 9000, 20);
      send(2, 10, "R9");
      send_w(1, 5, "R9", 2, 0, 1, 0);
      send(1, 5, "R9");

      // R8 backpressure
      len_write(5);
      @(negedge clk);
      rsp_ready = 1'b0;
      exp_q.push_back(expect_of(0, 16'd7));
      tag_q.push_back("R8");
      req_valid = 1'b1; req_seg = 0; req_off = 7;
      @(posedge clk);
      @(negedge clk);
      req_seg = 4; req_off = 1;
      check(rsp_valid == 1'b1, "R8", "rsp_valid while stalled", int'(rsp_valid), 1);
      check(req_ready == 1'b0, "R8", "req_ready while stalled", int'(req_ready), 0);
      held = rsp_paddr;
      repeat (3) @(negedge clk);
      check(rsp_paddr == held, "R8", "paddr held", int'(rsp_paddr), int'(held));
      check(req_ready == 1'b0, "R8", "req_ready still low", int'(req_ready), 0);
      exp_q.push_back(expect_of(4, 16'd1));
      tag_q.push_back("R8");
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule